// File: doc/BRIEF.md
# Trigger Latency Pipeline with Event Buffer

This block sits behind a multi-channel ADC. It keeps a running history of every sample in a circular store. A level-1 trigger reaches the front end long after the samples it refers to were digitised. When that trigger arrives, the block looks back into the history and copies a fixed window of consecutive samples into an event slot. Each sample beat carries every channel at once.

The latency is set by a configuration input and runs from zero to 240 sample periods. The block holds up to eight pending events. A new trigger is accepted while earlier events are still waiting or being streamed out. Events leave in trigger order over a valid/ready port, one beat per sample, with the twelfth beat flagged as the last. A trigger that finds every slot taken is dropped, and a counter records it. Samples come at six per beam crossing, so a 12-sample window spans two crossings.

Top module: `tlp_trigger_pipe`

## Requirements
- R1: While reset is held and just after it, `out_valid` is 0, `busy` is 0, `empty` is 1 and `rej_cnt` is 0.
- R2: Let sample n be the sample presented with `samp_valid` on the same clock edge as an accepted `trig`. With an effective latency L, the event holds samples n-L through n-L+11, streamed oldest first. Channel c of each beat sits in `out_data[12c+11:12c]`.
- R3: The effective latency equals `lat_cfg` for values 0 to 240. Any larger value is treated as 240.
- R4: If samples of a window have not yet arrived, the event waits for them. `out_valid` stays 0 until all 12 samples of the oldest event have been written.
- R5: Up to 8 events are held at once. `busy` is 1 exactly while all 8 slots are occupied.
- R6: A trigger that arrives while `busy` is 1 creates no event. It increments `rej_cnt`, which saturates at its maximum.
- R7: Events are delivered in the order their triggers were accepted.
- R8: Each event is 12 beats long, and `out_last` is 1 only on the twelfth beat. A slot stays occupied until that last beat is accepted (`out_valid` and `out_ready` both 1).
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.
- R10: The latency is taken from `lat_cfg` only on cycles with no trigger and no window still being copied. A trigger that arrives while a copy is pending uses the previously taken value.
- R11: `empty` is 1 exactly when no slot is occupied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | A new sample word is present |
| samp_data | input | NUM_CH*12 | One 12-bit sample per channel |
| trig | input | 1 | Level-1 trigger, one cycle per trigger |
| lat_cfg | input | LAT_W (8) | Requested trigger latency in samples |
| out_valid | output | 1 | Readout beat available |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | NUM_CH*12 | Readout sample word, all channels |
| out_last | output | 1 | Final beat of the event |
| busy | output | 1 | All event slots occupied |
| empty | output | 1 | No event slot occupied |
| rej_cnt | output | CNT_W (8) | Saturating count of rejected triggers |

## Verification
On every cycle, the assertions check the following:
- the slot ring never holds more than eight events;
- a trigger into a full ring leaves the allocation pointer untouched and bumps the reject count;
- the latency register stays frozen while a copy is pending;
- the readout pointer moves only on an accepted last beat;
- a stalled beat holds its data.

Other behaviour can only be shown by the bench scenarios, which compare against a sample pattern whose values encode their own index:
- whether the captured window starts at the right sample for each latency, including zero, small values, the maximum and the clamped values;
- whether an event waits through a gap in the sample stream;
- whether events come out in trigger order under back-pressure.

// File: rtl/tlp_pkg.sv
package tlp_pkg;

   localparam int unsigned TLP_SAMPLE_W = 12;

   // Smallest power of two that covers the deepest look-back plus a full
   // backlog of uncopied windows, so history is never overwritten early.
   function automatic int unsigned tlp_hist_depth(input int unsigned max_lat,
                                                   input int unsigned slots,
                                                   input int unsigned win);
      int unsigned need;
      int unsigned d;
      need = max_lat + slots * win + win + 1;
      d = 1;
      while (d < need) d = d << 1;
      return d;
   endfunction

endpackage

// File: rtl/tlp_history.sv
module tlp_history #(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned DEPTH    = 512,
   localparam int unsigned AW      = $clog2(DEPTH),
   localparam int unsigned DW      = NUM_CH * SAMPLE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] wr_ptr
);

   logic [AW-1:0] wr_ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) wr_ptr_q <= '0;
      else if (wr_en) wr_ptr_q <= wr_ptr_q + 1'b1;
   end

   assign wr_ptr = wr_ptr_q;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [SAMPLE_W-1:0] ring [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en) ring[wr_ptr_q] <= wr_data[ch*SAMPLE_W +: SAMPLE_W];
      end

      assign rd_data[ch*SAMPLE_W +: SAMPLE_W] = ring[rd_addr];
   end

   AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(wr_ptr_q)); // R2

endmodule

// File: rtl/tlp_slot_ctrl.sv
module tlp_slot_ctrl #(
   parameter int unsigned SLOTS        = 8,
   parameter int unsigned MAX_LAT      = 240,
   parameter int unsigned LAT_W        = 8,
   parameter int unsigned AW           = 9,
   parameter int unsigned CNT_W        = 8,
   parameter bit          REJ_SATURATE = 1'b1,
   localparam int unsigned SIW         = $clog2(SLOTS),
   localparam int unsigned SPW         = SIW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic [LAT_W-1:0] lat_cfg,
   input  logic [AW-1:0]    wr_ptr,
   input  logic             cap_done,
   input  logic             rd_done,
   output logic             cap_pending,
   output logic [SIW-1:0]   cap_slot,
   output logic [AW-1:0]    cap_start,
   output logic             rd_avail,
   output logic [SIW-1:0]   rd_slot,
   output logic             busy,
   output logic             empty,
   output logic [CNT_W-1:0] rej_cnt
);

   logic [SPW-1:0]   tail_q, cap_q, head_q;
   logic [SPW-1:0]   occ;
   logic             full, accept, reject;
   logic [LAT_W-1:0] lat_q, lat_lim;
   logic [AW-1:0]    start_q [SLOTS];
   logic [CNT_W-1:0] rej_q, rej_next;

   assign occ     = tail_q - head_q;
   assign full    = (occ == SPW'(SLOTS));
   assign accept  = trig && !full;
   assign reject  = trig && full;
   assign lat_lim = (lat_cfg > LAT_W'(MAX_LAT)) ? LAT_W'(MAX_LAT) : lat_cfg;

   if (REJ_SATURATE) begin : g_rej_sat
      assign rej_next = (rej_q == {CNT_W{1'b1}}) ? rej_q : rej_q + 1'b1;
   end else begin : g_rej_wrap
      assign rej_next = rej_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tail_q <= '0;
         cap_q  <= '0;
         head_q <= '0;
         lat_q  <= '0;
         rej_q  <= '0;
      end else begin
         if (accept)   tail_q <= tail_q + 1'b1;
         if (reject)   rej_q  <= rej_next;
         if (cap_done) cap_q  <= cap_q + 1'b1;
         if (rd_done)  head_q <= head_q + 1'b1;
         if (!cap_pending && !trig) lat_q <= lat_lim;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) start_q[tail_q[SIW-1:0]] <= wr_ptr - AW'(lat_q);
   end

   assign cap_pending = (cap_q != tail_q);
   assign cap_slot    = cap_q[SIW-1:0];
   assign cap_start   = start_q[cap_slot];
   assign rd_avail    = (head_q != cap_q);
   assign rd_slot     = head_q[SIW-1:0];
   assign busy        = full;
   assign empty       = (occ == '0);
   assign rej_cnt     = rej_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= SPW'(SLOTS)); // R5
   AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && busy) |=> $stable(tail_q)); // R6
   AST_REJ_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && busy && rej_cnt != {CNT_W{1'b1}}) |=> rej_cnt == CNT_W'($past(rej_cnt) + 1'b1)); // R6
   AST_LAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pending |=> $stable(lat_q)); // R10
   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_done |=> $stable(head_q)); // R8
   AST_PTR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      SPW'(tail_q - cap_q) <= SPW'(tail_q - head_q)); // R7

endmodule

// File: rtl/tlp_event_store.sv
module tlp_event_store #(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned SLOTS    = 8,
   parameter int unsigned WIN      = 12,
   parameter int unsigned AW       = 9,
   localparam int unsigned SIW     = $clog2(SLOTS),
   localparam int unsigned IW      = $clog2(WIN),
   localparam int unsigned EW      = $clog2(SLOTS * WIN),
   localparam int unsigned DW      = NUM_CH * SAMPLE_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  wr_ptr,
   input  logic           cap_pending,
   input  logic [SIW-1:0] cap_slot,
   input  logic [AW-1:0]  cap_start,
   output logic [AW-1:0]  hist_addr,
   input  logic [DW-1:0]  hist_data,
   output logic           cap_done,
   input  logic           rd_avail,
   input  logic [SIW-1:0] rd_slot,
   input  logic           out_ready,
   output logic           out_valid,
   output logic [DW-1:0]  out_data,
   output logic           out_last,
   output logic           rd_done
);

   logic [IW-1:0] cap_idx_q, rd_idx_q;
   logic [AW-1:0] ahead;
   logic          written, copy, cap_last, beat;
   logic [EW-1:0] cap_eaddr, rd_eaddr;

   // A sample is in the history once the write pointer has moved past it.
   assign hist_addr = cap_start + AW'(cap_idx_q);
   assign ahead     = hist_addr - wr_ptr;
   assign written   = (ahead >= AW'(WIN));
   assign copy      = cap_pending && written;
   assign cap_last  = (cap_idx_q == IW'(WIN - 1));
   assign cap_done  = copy && cap_last;

   assign cap_eaddr = EW'(cap_slot) * EW'(WIN) + EW'(cap_idx_q);
   assign rd_eaddr  = EW'(rd_slot) * EW'(WIN) + EW'(rd_idx_q);

   assign out_valid = rd_avail;
   assign out_last  = (rd_idx_q == IW'(WIN - 1));
   assign beat      = out_valid && out_ready;
   assign rd_done   = beat && out_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_idx_q <= '0;
         rd_idx_q  <= '0;
      end else begin
         if (copy) cap_idx_q <= cap_last ? '0 : cap_idx_q + 1'b1;
         if (beat) rd_idx_q  <= out_last ? '0 : rd_idx_q + 1'b1;
      end
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [SAMPLE_W-1:0] evt [SLOTS * WIN];

      always_ff @(posedge clk) begin
         if (copy) evt[cap_eaddr] <= hist_data[ch*SAMPLE_W +: SAMPLE_W];
      end

      assign out_data[ch*SAMPLE_W +: SAMPLE_W] = evt[rd_eaddr];
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
   AST_LAST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && out_last) |=> !out_last); // R8
   AST_CAP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_pending && hist_addr == wr_ptr) |=> $stable(cap_idx_q) || !cap_pending); // R4

endmodule

// File: rtl/tlp_trigger_pipe.sv
module tlp_trigger_pipe #(
   parameter int unsigned NUM_CH       = 2,
   parameter int unsigned SAMPLE_W     = tlp_pkg::TLP_SAMPLE_W,
   parameter int unsigned WIN          = 12,
   parameter int unsigned SLOTS        = 8,
   parameter int unsigned MAX_LAT      = 240,
   parameter int unsigned LAT_W        = $clog2(MAX_LAT + 1),
   parameter int unsigned CNT_W        = 8,
   parameter bit          REJ_SATURATE = 1'b1,
   localparam int unsigned HIST_DEPTH  = tlp_pkg::tlp_hist_depth(MAX_LAT, SLOTS, WIN),
   localparam int unsigned AW          = $clog2(HIST_DEPTH),
   localparam int unsigned SIW         = $clog2(SLOTS),
   localparam int unsigned DW          = NUM_CH * SAMPLE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             samp_valid,
   input  logic [DW-1:0]    samp_data,
   input  logic             trig,
   input  logic [LAT_W-1:0] lat_cfg,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [DW-1:0]    out_data,
   output logic             out_last,
   output logic             busy,
   output logic             empty,
   output logic [CNT_W-1:0] rej_cnt
);

   initial begin
      AST_SLOTS_POW2: assert (SLOTS >= 2 && (SLOTS & (SLOTS - 1)) == 0)
         else $error("SLOTS must be a power of two, at least 2"); // R5
      AST_WIN_SIZE: assert (WIN >= 2)
         else $error("WIN must be at least 2"); // R8
      AST_LAT_FITS: assert ((1 << LAT_W) > MAX_LAT)
         else $error("LAT_W too narrow for MAX_LAT"); // R3
      AST_CNT_SIZE: assert (CNT_W >= 1)
         else $error("CNT_W must be positive"); // R6
   end

   logic [AW-1:0]  wr_ptr, hist_addr, cap_start;
   logic [DW-1:0]  hist_data;
   logic           cap_pending, cap_done, rd_avail, rd_done;
   logic [SIW-1:0] cap_slot, rd_slot;

   tlp_history #(
      .NUM_CH   (NUM_CH),
      .SAMPLE_W (SAMPLE_W),
      .DEPTH    (HIST_DEPTH)
   ) u_history (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (samp_valid),
      .wr_data (samp_data),
      .rd_addr (hist_addr),
      .rd_data (hist_data),
      .wr_ptr  (wr_ptr)
   );

   tlp_slot_ctrl #(
      .SLOTS        (SLOTS),
      .MAX_LAT      (MAX_LAT),
      .LAT_W        (LAT_W),
      .AW           (AW),
      .CNT_W        (CNT_W),
      .REJ_SATURATE (REJ_SATURATE)
   ) u_slots (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig        (trig),
      .lat_cfg     (lat_cfg),
      .wr_ptr      (wr_ptr),
      .cap_done    (cap_done),
      .rd_done     (rd_done),
      .cap_pending (cap_pending),
      .cap_slot    (cap_slot),
      .cap_start   (cap_start),
      .rd_avail    (rd_avail),
      .rd_slot     (rd_slot),
      .busy        (busy),
      .empty       (empty),
      .rej_cnt     (rej_cnt)
   );

   tlp_event_store #(
      .NUM_CH   (NUM_CH),
      .SAMPLE_W (SAMPLE_W),
      .SLOTS    (SLOTS),
      .WIN      (WIN),
      .AW       (AW)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ptr      (wr_ptr),
      .cap_pending (cap_pending),
      .cap_slot    (cap_slot),
      .cap_start   (cap_start),
      .hist_addr   (hist_addr),
      .hist_data   (hist_data),
      .cap_done    (cap_done),
      .rd_avail    (rd_avail),
      .rd_slot     (rd_slot),
      .out_ready   (out_ready),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .out_last    (out_last),
      .rd_done     (rd_done)
   );

   AST_BUSY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && empty)); // R11
   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !out_valid); // R11

endmodule

// File: tb/tlp_trigger_pipe_bench.sv
`timescale 1ns/1ps
module tlp_trigger_pipe_bench;

   localparam int NUM_CH = 2;
   localparam int SW     = 12;
   localparam int WIN    = 12;
   localparam int DW     = NUM_CH * SW;

   // requested latency, expected effective latency, stall readout
   localparam int VECS [7][3] = '{
      '{0,   0,   0},
      '{5,   5,   1},
      '{11,  11,  0},
      '{12,  12,  1},
      '{100, 100, 0},
      '{240, 240, 1},
      '{250, 240, 0}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          samp_valid;
   logic [DW-1:0] samp_data;
   logic          trig;
   logic [7:0]    lat_cfg;
   logic          out_valid, out_ready, out_last, busy, empty;
   logic [DW-1:0] out_data;
   logic [7:0]    rej_cnt;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit gen_en = 1'b0;
   int sent   = 0;

   always #10 clk = ~clk;

   tlp_trigger_pipe u_tlp_trigger_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_valid (samp_valid),
      .samp_data  (samp_data),
      .trig       (trig),
      .lat_cfg    (lat_cfg),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_data   (out_data),
      .out_last   (out_last),
      .busy       (busy),
      .empty      (empty),
      .rej_cnt    (rej_cnt)
   );

   function automatic logic [DW-1:0] pat(input int n);
      logic [DW-1:0] r;
      for (int c = 0; c < NUM_CH; c++) r[c*SW +: SW] = SW'((n + 256 * c) & 'hFFF);
      return r;
   endfunction

   initial begin
      samp_valid = 1'b0;
      samp_data  = '0;
      forever begin
         @(negedge clk);
         if (gen_en) begin
            samp_data  = pat(sent);
            samp_valid = 1'b1;
            sent       = sent + 1;
         end else begin
            samp_valid = 1'b0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_trig(output int idx);
      @(negedge clk);
      #1;
      idx  = samp_valid ? sent - 1 : sent;
      trig = 1'b1;
      @(negedge clk);
      #1;
      trig = 1'b0;
   endtask

   task automatic wait_idle();
      while (!empty) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic read_event(input int start, input bit stall, input bit chk_free, input string req);
      int bad = 0;
      int lastbad = 0;
      logic [DW-1:0] bad_act = '0;
      logic [DW-1:0] bad_exp = '0;
      for (int k = 0; k < WIN; k++) begin
         if (stall && (k % 2 == 1)) begin
            out_ready = 1'b0;
            @(negedge clk);
         end
         while (!out_valid) @(negedge clk);
         if (out_data !== pat(start + k)) begin
            if (bad == 0) begin
               bad_act = out_data;
               bad_exp = pat(start + k);
            end
            bad++;
         end
         if (out_last !== (k == WIN - 1)) lastbad++;
         if (chk_free && k == WIN - 1) check(busy == 1'b1, "R8", "slot held before last beat", busy, 1);
         out_ready = 1'b1;
         @(negedge clk);
         out_ready = 1'b0;
      end
      check(bad == 0, req, "event window data", bad_act, bad_exp);
      check(lastbad == 0, "R8", "last flag misplaced count", lastbad, 0);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n, a, b, c;
      int idxs [8];
      rst_n     = 1'b0;
      trig      = 1'b0;
      lat_cfg   = 8'd0;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      check(busy == 1'b0 && empty == 1'b1, "R1", "busy/empty in reset", {busy, empty}, 2'b01);
      check(rej_cnt == 8'd0, "R1", "rej_cnt in reset", rej_cnt, 0);
      rst_n  = 1'b1;
      gen_en = 1'b1;
      repeat (300) @(negedge clk);
      check(empty == 1'b1 && out_valid == 1'b0, "R1", "idle after reset", {empty, out_valid}, 2'b10);

      // Table of latency vectors
      for (int v = 0; v < 7; v++) begin
         lat_cfg = 8'(VECS[v][0]);
         repeat (4) @(negedge clk);
         pulse_trig(n);
         read_event(n - VECS[v][1], VECS[v][2] != 0, 1'b0, (v == 6) ? "R3" : "R2");
         check(empty == 1'b1, "R11", "empty after readout", empty, 1);
      end

      // R4: a gap in the sample stream holds the event back
      lat_cfg = 8'd3;
      wait_idle();
      pulse_trig(n);
      gen_en = 1'b0;
      repeat (30) @(negedge clk);
      check(out_valid == 1'b0, "R4", "event held while samples missing", out_valid, 0);
      gen_en = 1'b1;
      read_event(n - 3, 1'b0, 1'b0, "R4");

      // R5/R6/R7: fill all slots, then overflow
      lat_cfg = 8'd20;
      wait_idle();
      for (int i = 0; i < 8; i++) pulse_trig(idxs[i]);
      check(busy == 1'b1, "R5", "busy with 8 events", busy, 1);
      check(empty == 1'b0, "R11", "not empty with events", empty, 0);
      pulse_trig(n);
      pulse_trig(n);
      check(rej_cnt == 8'd2, "R6", "rejected trigger count", rej_cnt, 2);
      check(busy == 1'b1, "R5", "busy after rejects", busy, 1);
      repeat (120) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         read_event(idxs[i] - 20, (i % 2) == 1, i == 0, "R7");
         if (i == 0) check(busy == 1'b0, "R8", "slot freed after last beat", busy, 0);
      end
      check(empty == 1'b1, "R11", "empty after draining", empty, 1);
      repeat (30) @(negedge clk);
      check(out_valid == 1'b0, "R6", "rejected triggers made no event", out_valid, 0);
      check(rej_cnt == 8'd2, "R6", "reject count held", rej_cnt, 2);

      // R10: latency change during a pending copy
      lat_cfg = 8'd50;
      wait_idle();
      pulse_trig(a);
      lat_cfg = 8'd10;
      pulse_trig(b);
      read_event(a - 50, 1'b0, 1'b0, "R10");
      read_event(b - 50, 1'b1, 1'b0, "R10");
      wait_idle();
      pulse_trig(c);
      read_event(c - 10, 1'b0, 1'b0, "R10");

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule